// File: doc/BRIEF.md
# Dual-Channel Voice Frame Deserializer

This block takes a serial frame that carries two voice channels and pulls it apart. A sync pulse marks where each frame starts, and a bit clock times the data. Each frame holds two 8-bit PCM samples. For each channel it also holds one power-enable bit and a 3-bit general-purpose latch field. All serial inputs are oversampled in the system clock domain, so the bit clock only has to be slow compared with that clock. Voice systems use bit clocks from 256 kHz to 4.096 MHz, with a new frame every 125 us.

Nothing reaches the outputs until the whole 28-bit frame has arrived. At that point the two PCM bytes are written to their output registers and a one-cycle strobe fires. The latch fields and the channel enables are updated at the same moment. An active-low run input works as a global power-down. While it is low, both channels are off and all six latch outputs, together with their stored bits, are held at zero.

Top module: `pcm_duo_deframer`

## Requirements
- R1: After reset, `pcm_ch1`, `pcm_ch2`, `pcm_valid`, `gp_ch1`, `gp_ch2` and `ch_en` are all zero.
- R2: A frame starts at a rising edge of `fsync`. Bits are taken on falling edges of `bclk`, and the first bit after the sync edge is the channel 1 sample MSB. A `bclk` falling edge that lands in the same system clock cycle as the `fsync` rising edge counts as bit 1 of the new frame.
- R3: The frame bit order is fixed:
  - bits 1..8: channel 1 sample, MSB first
  - bit 9: channel 1 enable
  - bits 10, 11, 12: channel 1 latch field, placed at `gp_ch1[2]`, `gp_ch1[1]` and `gp_ch1[0]`
  - bits 13..24: the same layout for channel 2, driving `pcm_ch2`, enable 2 and `gp_ch2`
- R4: The outputs change only when bit 28 has been taken. `pcm_valid` is high for exactly one cycle per completed frame, and the PCM outputs hold their value between strobes.
- R5: Bits 25..28 do not affect any output. Bits after bit 28 and before the next `fsync` rising edge are ignored, so no extra strobe occurs.
- R6: A new `fsync` rising edge in the middle of a frame restarts the bit count. The partial frame is discarded and produces no strobe.
- R7: `ch_en[0]` is 1 exactly when `pwr_run` is 1 and the last stored channel 1 enable bit is 1. `ch_en[1]` follows the same rule for channel 2.
- R8: While `pwr_run` is 0, `gp_ch1`, `gp_ch2` and `ch_en` are 0, and the stored latch and enable bits are cleared. Frames received during this time still deliver PCM bytes and strobes, but they load no latch or enable bits.
- R9: While `pwr_run` is 1, `gp_ch1` and `gp_ch2` show the latch bits of the last completed frame, whatever its enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| fsync | input | 1 | Frame sync; its rising edge marks bit 1 |
| sdin | input | 1 | Serial frame data |
| pwr_run | input | 1 | Global run control; 0 powers down both channels and clears the latches |
| pcm_ch1 | output | 8 | Channel 1 PCM sample from the last completed frame |
| pcm_ch2 | output | 8 | Channel 2 PCM sample from the last completed frame |
| pcm_valid | output | 1 | One-cycle strobe when a completed frame is committed |
| gp_ch1 | output | 3 | Channel 1 general-purpose latch outputs |
| gp_ch2 | output | 3 | Channel 2 general-purpose latch outputs |
| ch_en | output | 2 | Channel power enables; bit 0 is channel 1 |

## Verification
Two events can fall in the same system clock cycle: the `fsync` rising edge and a `bclk` falling edge. In that case the block has to both restart its count and take the bit as bit 1 of the new frame. The bench provokes this by dropping `bclk` and raising `fsync` at the same instant, so both pass through equal synchronizer depth. It then checks the PCM bytes and latch fields of that frame, which would come out shifted by one bit if the coincident bit were lost or counted twice. A power-down that overlaps a commit is a second coincidence: the clear must win. The bench checks this by sending a frame with all latch bits set while `pwr_run` is low.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

  localparam int PCM_W     = 8;
  localparam int LATCH_W   = 3;
  localparam int SLOT_W    = PCM_W + 1 + LATCH_W;
  localparam int N_CH      = 2;
  localparam int PAYLOAD_W = SLOT_W * N_CH;

  // one channel's slot, MSB first as it arrives on the wire
  typedef struct packed {
    logic [PCM_W-1:0]   pcm;
    logic               pwr;
    logic [LATCH_W-1:0] latch;
  } slot_t;

  // store the bit with arrival index idx (0 = first bit) into the payload
  function automatic logic [PAYLOAD_W-1:0] place_bit(
    input logic [PAYLOAD_W-1:0] pay,
    input int                   idx,
    input logic                 b
  );
    logic [PAYLOAD_W-1:0] r;
    r = pay;
    r[PAYLOAD_W-1-idx] = b;
    return r;
  endfunction

  // pick channel k's slot out of the payload
  function automatic slot_t slot_of(
    input logic [PAYLOAD_W-1:0] pay,
    input int                   k
  );
    return pay[PAYLOAD_W-1-k*SLOT_W -: SLOT_W];
  endfunction

endpackage

// File: rtl/pcmrx_insync.sv
module pcmrx_insync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end

endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer
  import pcmrx_pkg::*;
#(
  parameter int FRAME_BITS = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_rise,
  input  logic                 bclk_fall,
  input  logic                 sbit,
  output logic                 frame_done,
  output logic [PAYLOAD_W-1:0] pay_nxt
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [CW-1:0]        cnt;
  logic                 active;
  logic [PAYLOAD_W-1:0] pay_q;
  logic [CW-1:0]        idx;
  logic                 shift_en;

  // a sync edge in the same cycle as a bit edge makes that bit number 0
  assign idx        = sync_rise ? '0 : cnt;
  assign shift_en   = bclk_fall && (active || sync_rise);
  assign frame_done = shift_en && (idx == CW'(FRAME_BITS - 1));

  always_comb begin
    pay_nxt = pay_q;
    if (shift_en && (int'(idx) < PAYLOAD_W))
      pay_nxt = place_bit(pay_q, int'(idx), sbit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      pay_q  <= '0;
    end else if (shift_en) begin
      pay_q  <= pay_nxt;
      cnt    <= idx + 1'b1;
      active <= !frame_done;
    end else if (sync_rise) begin
      cnt    <= '0;
      active <= 1'b1;
    end
  end

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (cnt <= CW'(1)) && active);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME_BITS));
  // R5
  idle_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !active);

endmodule

// File: rtl/pcmrx_ctrl.sv
module pcmrx_ctrl
  import pcmrx_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             commit,
  input  logic [PAYLOAD_W-1:0]             pay,
  output logic [N_CH-1:0][PCM_W-1:0]       pcm_o,
  output logic                             valid_o,
  output logic [N_CH-1:0][LATCH_W-1:0]     gp_o,
  output logic [N_CH-1:0]                  en_o
);

  logic [N_CH-1:0][PCM_W-1:0]   pcm_q;
  logic [N_CH-1:0][LATCH_W-1:0] lat_q;
  logic [N_CH-1:0]              pwr_q;
  logic                         valid_q;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    slot_t s;
    assign s = slot_of(pay, k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcm_q[k] <= '0;
        lat_q[k] <= '0;
        pwr_q[k] <= 1'b0;
      end else begin
        if (commit) pcm_q[k] <= s.pcm;
        // power-down clears the stored control bits and wins over a commit
        if (!run) begin
          lat_q[k] <= '0;
          pwr_q[k] <= 1'b0;
        end else if (commit) begin
          lat_q[k] <= s.latch;
          pwr_q[k] <= s.pwr;
        end
      end
    end

    assign gp_o[k] = run ? lat_q[k] : '0;
    assign en_o[k] = run & pwr_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= commit;
  end

  assign pcm_o   = pcm_q;
  assign valid_o = valid_q;

  // R8
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lat_q == '0) && (pwr_q == '0));
  // R4
  pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pcm_q));
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7
  en_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> (pwr_q == '0));

endmodule

// File: rtl/pcm_duo_deframer.sv
module pcm_duo_deframer
  import pcmrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic         sdin,
  input  logic         pwr_run,
  output logic [7:0]   pcm_ch1,
  output logic [7:0]   pcm_ch2,
  output logic         pcm_valid,
  output logic [2:0]   gp_ch1,
  output logic [2:0]   gp_ch2,
  output logic [1:0]   ch_en
);

  // [0] bit clock, [1] frame sync
  logic [1:0] edge_q, edge_d;
  // [0] serial data, [1] run control
  logic [1:0] lvl_q;

  pcmrx_insync #(.STAGES(SYNC_STAGES), .N(2)) u_edge_sync (
    .clk, .rst_n, .d({fsync, bclk}), .q(edge_q)
  );

  pcmrx_insync #(.STAGES(SYNC_STAGES), .N(2)) u_lvl_sync (
    .clk, .rst_n, .d({pwr_run, sdin}), .q(lvl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_d <= '0;
    else        edge_d <= edge_q;
  end

  logic bclk_fall, sync_rise, run_s, frame_done;
  logic [PAYLOAD_W-1:0] pay_nxt;

  assign bclk_fall = edge_d[0] & ~edge_q[0];
  assign sync_rise = edge_q[1] & ~edge_d[1];
  assign run_s     = lvl_q[1];

  pcmrx_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk, .rst_n,
    .sync_rise (sync_rise),
    .bclk_fall (bclk_fall),
    .sbit      (lvl_q[0]),
    .frame_done(frame_done),
    .pay_nxt   (pay_nxt)
  );

  logic [N_CH-1:0][PCM_W-1:0]   pcm_w;
  logic [N_CH-1:0][LATCH_W-1:0] gp_w;

  pcmrx_ctrl u_ctrl (
    .clk, .rst_n,
    .run    (run_s),
    .commit (frame_done),
    .pay    (pay_nxt),
    .pcm_o  (pcm_w),
    .valid_o(pcm_valid),
    .gp_o   (gp_w),
    .en_o   (ch_en)
  );

  assign pcm_ch1 = pcm_w[0];
  assign pcm_ch2 = pcm_w[1];
  assign gp_ch1  = gp_w[0];
  assign gp_ch2  = gp_w[1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_valid) |-> $past(frame_done));

endmodule

// File: tb/pcm_duo_deframer_tb_top.sv
`timescale 1ns/1ps
module pcm_duo_deframer_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, pwr_run = 1'b0;
  logic [7:0] pcm_ch1, pcm_ch2;
  logic pcm_valid;
  logic [2:0] gp_ch1, gp_ch2;
  logic [1:0] ch_en;

  always #4 clk = ~clk;

  pcm_duo_deframer dut_i (
    .clk, .rst_n, .bclk, .fsync, .sdin, .pwr_run,
    .pcm_ch1, .pcm_ch2, .pcm_valid, .gp_ch1, .gp_ch2, .ch_en
  );

  typedef struct { logic [7:0] a; logic [7:0] b; } exp_t;
  exp_t expq[$];

  int checks = 0, failures = 0, nvalid = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] mk(input logic [7:0] p1, input logic c1, input logic [2:0] l1,
                                     input logic [7:0] p2, input logic c2, input logic [2:0] l2,
                                     input logic [3:0] e);
    return {p1, c1, l1, p2, c2, l2, e};
  endfunction

  // driver: pushes the expectation, then shifts the frame out
  task automatic send(input logic [27:0] f, input int nbits, input bit coinc,
                      input int extra, input bit expect_it);
    if (expect_it) expq.push_back('{f[27:20], f[15:8]});
    for (int i = 0; i < nbits + extra; i++) begin
      @(negedge clk);
      bclk = 1'b1;
      sdin = (i < nbits) ? f[27-i] : i[0];
      if (i == 0 && !coinc) fsync = 1'b1;
      if (i == 1) fsync = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      bclk = 1'b0;
      if (i == 0 && coinc) fsync = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  // monitor: compares every strobe against the queue
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcm_valid && prev_valid) begin
        checks++; failures++;
        $display("FAIL R4 strobe wider than one cycle actual=2 expected=1");
      end
      if (pcm_valid) begin
        nvalid++;
        if (expq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R4 unexpected strobe actual=%0h_%0h expected=none", pcm_ch1, pcm_ch2);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk("R3 ch1 sample", {24'h0, pcm_ch1}, {24'h0, e.a});
          chk("R3 ch2 sample", {24'h0, pcm_ch2}, {24'h0, e.b});
        end
      end
      prev_valid = pcm_valid;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int nv;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 pcm_ch1", {24'h0, pcm_ch1}, 0);
    chk("R1 pcm_ch2", {24'h0, pcm_ch2}, 0);
    chk("R1 pcm_valid", {31'h0, pcm_valid}, 0);
    chk("R1 gp", {26'h0, gp_ch1, gp_ch2}, 0);
    chk("R1 ch_en", {30'h0, ch_en}, 0);
    rst_n = 1'b1;
    pwr_run = 1'b1;
    settle();

    // R9 R7 normal frame, both channels on
    send(mk(8'hA5, 1, 3'b101, 8'h3C, 1, 3'b010, 4'hF), 28, 0, 0, 1);
    settle();
    chk("R9 gp_ch1", {29'h0, gp_ch1}, 5);
    chk("R9 gp_ch2", {29'h0, gp_ch2}, 2);
    chk("R7 ch_en both", {30'h0, ch_en}, 3);

    // R2 sync rise coincident with a bit clock falling edge
    send(mk(8'h81, 0, 3'b011, 8'h7E, 1, 3'b110, 4'h0), 28, 1, 0, 1);
    settle();
    chk("R2 gp_ch1 coincident", {29'h0, gp_ch1}, 3);
    chk("R2 gp_ch2 coincident", {29'h0, gp_ch2}, 6);
    chk("R7 ch_en ch2 only", {30'h0, ch_en}, 2);

    // R5 trailing bits after bit 28 ignored
    nv = nvalid;
    send(mk(8'h0F, 1, 3'b000, 8'hF0, 0, 3'b111, 4'hA), 28, 0, 6, 1);
    settle();
    chk("R5 one strobe", nvalid - nv, 1);
    chk("R5 gp_ch2", {29'h0, gp_ch2}, 7);
    chk("R7 ch_en ch1 only", {30'h0, ch_en}, 1);

    // R6 truncated frame produces nothing
    nv = nvalid;
    send(mk(8'hEE, 0, 3'b111, 8'h11, 0, 3'b000, 4'h5), 15, 0, 0, 0);
    settle();
    chk("R6 no strobe on partial", nvalid - nv, 0);
    chk("R4 ch1 held", {24'h0, pcm_ch1}, 32'h0F);
    // R6 restart straight into a full frame
    send(mk(8'h99, 1, 3'b100, 8'h66, 1, 3'b001, 4'h3), 10, 0, 0, 0);
    send(mk(8'h55, 1, 3'b110, 8'hAA, 1, 3'b011, 4'hC), 28, 0, 0, 1);
    settle();
    chk("R6 one strobe after restart", nvalid - nv, 1);
    chk("R6 gp_ch1", {29'h0, gp_ch1}, 6);

    // R8 global power-down
    pwr_run = 1'b0;
    settle();
    chk("R8 gp zero", {26'h0, gp_ch1, gp_ch2}, 0);
    chk("R8 ch_en zero", {30'h0, ch_en}, 0);
    send(mk(8'h12, 1, 3'b111, 8'h34, 1, 3'b111, 4'h0), 28, 0, 0, 1);
    settle();
    chk("R8 gp zero after frame", {26'h0, gp_ch1, gp_ch2}, 0);
    chk("R8 ch_en zero after frame", {30'h0, ch_en}, 0);
    pwr_run = 1'b1;
    settle();
    chk("R8 latches cleared", {26'h0, gp_ch1, gp_ch2}, 0);
    chk("R8 enables cleared", {30'h0, ch_en}, 0);

    // R9 latch bits shown even with both channels disabled
    send(mk(8'hC3, 0, 3'b110, 8'h5A, 0, 3'b001, 4'h9), 28, 0, 0, 1);
    settle();
    chk("R9 gp_ch1 cpd off", {29'h0, gp_ch1}, 6);
    chk("R9 gp_ch2 cpd off", {29'h0, gp_ch2}, 1);
    chk("R7 ch_en off", {30'h0, ch_en}, 0);

    chk("R4 queue drained", expq.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule